// File: doc/BRIEF.md
# Up/Down Timer Counter with Buffered Compare

This block is the counting core of a general-purpose timer. An 8-bit count register is advanced by a single-cycle enable tick. That tick comes from a clock-select or prescaler stage that sits outside the block. A two-bit mode input picks one of three sequences:
- Free-running wrap.
- Clear-on-compare, where the compare value sets the top of the count.
- Triangle, which counts up to all-ones and back down to zero.

The block reports, without a clock delay, whether the count is at zero, at all-ones, or at the top of the current sequence.

A compare value is held in two stages, a write buffer and an active copy. The active copy is compared with the count on every tick. A hit gives a one-cycle strobe for a downstream waveform generator and also sets a sticky compare flag. A sticky overflow flag marks the wrap or turnaround point of each sequence. Software-style write strobes load the count and the compare value. Each sticky flag has its own clear strobe.

Top module: `tmr_updown_top`

## Requirements
- R1: After reset, `count`, `cmp_value`, `ovf_flag` and `cmp_flag` are 0 and `at_bottom` is 1.
- R2: In mode 0 (and in mode 3, which behaves the same), each tick raises `count` by one. A tick taken at 0xFF gives 0x00 and sets `ovf_flag`.
- R3: In mode 1, a tick taken when `count` equals the active compare value clears `count` to 0. Any other tick raises it by one. A tick taken at 0xFF also sets `ovf_flag`.
- R4: In mode 2, `count` steps by one per tick. It climbs to 0xFF, then falls to 0x00, then climbs again. A tick taken at 0x00 sets `ovf_flag`.
- R5: Without a tick or a count write, `count` keeps its value.
- R6: `at_bottom` is high at 0x00 and `at_max` is high at 0xFF. `at_top` is high when `count` equals the top of the sequence: `cmp_value` in mode 1, 0xFF in every other mode.
- R7: In modes 0 and 3, a compare write shows up on `cmp_value` in the next cycle.
- R8: In modes 1 and 2, a compare write goes only into the buffer. The buffer moves into `cmp_value` on a tick taken at the top (mode 1) or at 0x00 (mode 2).
- R9: `match_pulse` is high in a cycle that has a tick while `count` equals `cmp_value`. `cmp_flag` is set one cycle later.
- R10: A count write takes priority over a tick in the same cycle. The written value appears on `count` in the next cycle.
- R11: In the cycle right after a count write, `match_pulse` stays low even when a tick arrives and the count equals the compare value.
- R12: A one-cycle pulse on `ovf_clr` or `cmp_clr` clears the matching flag. If a set and a clear land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one cycle per timer step |
| mode | input | 2 | Sequence select: 0 wrap, 1 clear-on-compare, 2 triangle, 3 wrap |
| cnt_wr | input | 1 | Load `count` from `wr_data` |
| cmp_wr | input | 1 | Write the compare value from `wr_data` |
| wr_data | input | 8 | Write data for count or compare |
| ovf_clr | input | 1 | Clear strobe for `ovf_flag` |
| cmp_clr | input | 1 | Clear strobe for `cmp_flag` |
| count | output | 8 | Current count |
| at_bottom | output | 1 | Count is 0x00 |
| at_max | output | 1 | Count is 0xFF |
| at_top | output | 1 | Count is at the top of the current sequence |
| cmp_value | output | 8 | Active compare value |
| match_pulse | output | 1 | One-cycle compare hit strobe |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a flag clear and the event that sets that flag. The bench loads the count to 0xFF and then, in one cycle, pulses the overflow clear together with the tick that wraps the count. It expects the flag to read set afterwards.

The second pair is a count write and the compare check. The bench writes a count equal to the compare value and ticks in the very next cycle. It expects no strobe and no flag, while the count still advances.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        TM_WRAP       = 2'd0,
        TM_CLR_AT_CMP = 2'd1,
        TM_TRIANGLE   = 2'd2,
        TM_WRAP_ALT   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic bottom;
        logic max;
        logic top;
    } tmr_lim_s;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_OVF  = 0;
    localparam int FLAG_CMP  = 1;

    function automatic logic top_from_cmp(tmr_mode_e m);
        return m == TM_CLR_AT_CMP;
    endfunction

    function automatic logic cmp_buffered(tmr_mode_e m);
        return (m == TM_CLR_AT_CMP) || (m == TM_TRIANGLE);
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt_q,
    output tmr_lim_s     lim,
    output logic         ovf_evt,
    output logic         reload_evt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ZERO = '0;

    logic         down_q, down_d;
    logic [W-1:0] cnt_d;
    logic [W-1:0] top_now;
    logic         step_ok;

    always_comb begin
        top_now    = top_from_cmp(mode) ? top_val : MAXV;
        lim.bottom = (cnt_q == ZERO);
        lim.max    = (cnt_q == MAXV);
        lim.top    = (cnt_q == top_now);
        step_ok    = tick && !wr_en;

        down_d = 1'b0;
        if (mode == TM_TRIANGLE) begin
            if (cnt_q == MAXV)      down_d = 1'b1;
            else if (cnt_q == ZERO) down_d = 1'b0;
            else                    down_d = down_q;
        end

        case (mode)
            TM_CLR_AT_CMP: cnt_d = (cnt_q == top_now) ? ZERO : cnt_q + 1'b1;
            TM_TRIANGLE:   cnt_d = down_d ? cnt_q - 1'b1 : cnt_q + 1'b1;
            default:       cnt_d = cnt_q + 1'b1;
        endcase

        ovf_evt = step_ok && ((mode == TM_TRIANGLE) ? (cnt_q == ZERO) : (cnt_q == MAXV));

        case (mode)
            TM_CLR_AT_CMP: reload_evt = step_ok && (cnt_q == top_now);
            TM_TRIANGLE:   reload_evt = step_ok && (cnt_q == ZERO);
            default:       reload_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= ZERO;
            down_q <= 1'b0;
        end else begin
            if (wr_en) begin
                cnt_q <= wr_data;
            end else if (tick) begin
                cnt_q  <= cnt_d;
                down_q <= down_d;
            end
            if (mode != TM_TRIANGLE) down_q <= 1'b0;
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !tick) |=> $stable(cnt_q)); // R5
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt_q == $past(wr_data))); // R10
    AST_CLR_BOUND: assert property (@(posedge clk) disable iff (rst)
        (mode == TM_CLR_AT_CMP && step_ok && cnt_q <= top_val) |=> (cnt_q <= $past(top_val))); // R3
    AST_TRI_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == TM_TRIANGLE && step_ok) |=>
        ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1))); // R4

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic         cmp_wr,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt_q,
    input  logic         reload_evt,
    output logic [W-1:0] act_q,
    output logic         match
);
    logic [W-1:0] buf_q;
    logic         hush_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            act_q  <= '0;
            hush_q <= 1'b0;
        end else begin
            hush_q <= cnt_wr;
            if (cmp_wr) buf_q <= wr_data;
            if (!cmp_buffered(mode)) begin
                if (cmp_wr) act_q <= wr_data;
            end else if (reload_evt) begin
                act_q <= buf_q;
            end
        end
    end

    always_comb match = tick && !hush_q && (cnt_q == act_q);

    AST_MATCH_HUSH: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !match); // R11
    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cmp_buffered(mode) && !reload_evt) |=> $stable(act_q)); // R8
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!cmp_buffered(mode) && cmp_wr) |=> (act_q == $past(wr_data))); // R7

endmodule

// File: rtl/tmr_sticky.sv
module tmr_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set |=> q); // R12
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q); // R12

endmodule

// File: rtl/tmr_updown_top.sv
module tmr_updown_top
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [1:0]   mode,
    input  logic         cnt_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] wr_data,
    input  logic         ovf_clr,
    input  logic         cmp_clr,
    output logic [W-1:0] count,
    output logic         at_bottom,
    output logic         at_max,
    output logic         at_top,
    output logic [W-1:0] cmp_value,
    output logic         match_pulse,
    output logic         ovf_flag,
    output logic         cmp_flag
);
    tmr_mode_e mode_e;
    tmr_lim_s  lim;
    logic      ovf_evt, reload_evt;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

    always_comb mode_e = tmr_mode_e'(mode);

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode_e),
        .wr_en(cnt_wr), .wr_data(wr_data), .top_val(cmp_value),
        .cnt_q(count), .lim(lim), .ovf_evt(ovf_evt), .reload_evt(reload_evt)
    );

    tmr_cmp_unit #(.W(W)) u_cmp (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode_e),
        .cmp_wr(cmp_wr), .cnt_wr(cnt_wr), .wr_data(wr_data),
        .cnt_q(count), .reload_evt(reload_evt),
        .act_q(cmp_value), .match(match_pulse)
    );

    always_comb begin
        flag_set[FLAG_OVF] = ovf_evt;
        flag_set[FLAG_CMP] = match_pulse;
        flag_clr[FLAG_OVF] = ovf_clr;
        flag_clr[FLAG_CMP] = cmp_clr;
        at_bottom = lim.bottom;
        at_max    = lim.max;
        at_top    = lim.top;
        ovf_flag  = flag_q[FLAG_OVF];
        cmp_flag  = flag_q[FLAG_CMP];
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        tmr_sticky u_flag (
            .clk(clk), .rst(rst), .set(flag_set[g]), .clr(flag_clr[g]), .q(flag_q[g])
        );
    end

    AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        match_pulse |=> cmp_flag); // R9

endmodule

// File: tb/tb_tmr_updown_top.sv
module tb_tmr_updown_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       cnt_wr = 1'b0, cmp_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ovf_clr = 1'b0, cmp_clr = 1'b0;
    logic [7:0] count, cmp_value;
    logic       at_bottom, at_max, at_top, match_pulse, ovf_flag, cmp_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmr_updown_top dut (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode),
        .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
        .count(count), .at_bottom(at_bottom), .at_max(at_max), .at_top(at_top),
        .cmp_value(cmp_value), .match_pulse(match_pulse),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk); cnt_wr = 1'b1; wr_data = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic wr_cmp(input logic [7:0] v);
        @(negedge clk); cmp_wr = 1'b1; wr_data = v;
        @(negedge clk); cmp_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_clr(input bit ovf, input bit cmp);
        ovf_clr = ovf; cmp_clr = cmp;
        @(negedge clk);
        ovf_clr = 1'b0; cmp_clr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 count", count, 8'h00);
        chk("R1 cmp_value", cmp_value, 8'h00);
        chk("R1 ovf_flag", ovf_flag, 1'b0);
        chk("R1 cmp_flag", cmp_flag, 1'b0);
        chk("R1 at_bottom", at_bottom, 1'b1);
    endtask

    task automatic t_wrap;
        mode = 2'd0;
        wr_cnt(8'hFD);
        chk("R10 count load", count, 8'hFD);
        ticks(1);
        chk("R2 step", count, 8'hFE);
        repeat (3) @(negedge clk);
        chk("R5 hold", count, 8'hFE);
        ticks(1);
        chk("R6 at_max", at_max, 1'b1);
        chk("R6 at_top mode0", at_top, 1'b1);
        ticks(1);
        chk("R2 wrap", count, 8'h00);
        chk("R2 ovf set", ovf_flag, 1'b1);
        chk("R6 at_bottom", at_bottom, 1'b1);
        pulse_clr(1'b1, 1'b0);
        chk("R12 ovf cleared", ovf_flag, 1'b0);
        wr_cnt(8'hFF);
        ovf_clr = 1'b1; tick = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0; tick = 1'b0;
        chk("R12 set wins", ovf_flag, 1'b1);
        pulse_clr(1'b1, 1'b0);
        mode = 2'd3;
        wr_cnt(8'hFF);
        ticks(1);
        chk("R2 mode3 wrap", count, 8'h00);
        chk("R2 mode3 ovf", ovf_flag, 1'b1);
        pulse_clr(1'b1, 1'b0);
    endtask

    task automatic t_match;
        mode = 2'd0;
        wr_cmp(8'h40);
        chk("R7 direct load", cmp_value, 8'h40);
        wr_cnt(8'h3F);
        ticks(1);
        chk("R9 reach", count, 8'h40);
        #1;
        chk("R9 no tick no strobe", match_pulse, 1'b0);
        @(negedge clk);
        tick = 1'b1; #1;
        chk("R9 strobe", match_pulse, 1'b1);
        @(negedge clk); tick = 1'b0;
        chk("R9 flag", cmp_flag, 1'b1);
        pulse_clr(1'b0, 1'b1);
        chk("R12 cmp cleared", cmp_flag, 1'b0);
        wr_cnt(8'h40);
        tick = 1'b1; #1;
        chk("R11 suppressed", match_pulse, 1'b0);
        @(negedge clk); tick = 1'b0;
        chk("R11 no flag", cmp_flag, 1'b0);
        chk("R11 still counts", count, 8'h41);
    endtask

    task automatic t_clear_mode;
        mode = 2'd0;
        wr_cmp(8'h05);
        mode = 2'd1;
        wr_cnt(8'h00);
        ticks(5);
        chk("R3 climb", count, 8'h05);
        chk("R6 at_top mode1", at_top, 1'b1);
        chk("R6 at_max low", at_max, 1'b0);
        wr_cmp(8'h02);
        chk("R8 buffered mode1", cmp_value, 8'h05);
        ticks(1);
        chk("R3 clear at top", count, 8'h00);
        chk("R8 reload at top", cmp_value, 8'h02);
        ticks(2);
        chk("R6 new top", at_top, 1'b1);
        ticks(1);
        chk("R3 clear new top", count, 8'h00);
        pulse_clr(1'b1, 1'b1);
    endtask

    task automatic t_triangle;
        mode = 2'd0;
        wr_cmp(8'h10);
        mode = 2'd2;
        wr_cnt(8'hFE);
        ticks(1);
        chk("R4 up", count, 8'hFF);
        ticks(1);
        chk("R4 turn down", count, 8'hFE);
        ticks(1);
        chk("R4 down", count, 8'hFD);
        wr_cmp(8'h20);
        chk("R8 buffered mode2", cmp_value, 8'h10);
        wr_cnt(8'h01);
        pulse_clr(1'b1, 1'b1);
        ticks(1);
        chk("R4 reach bottom", count, 8'h00);
        chk("R4 no ovf yet", ovf_flag, 1'b0);
        ticks(1);
        chk("R4 turn up", count, 8'h01);
        chk("R4 ovf at bottom", ovf_flag, 1'b1);
        chk("R8 reload at bottom", cmp_value, 8'h20);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wrap();
        t_match();
        t_clear_mode();
        t_triangle();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end
endmodule